// File: doc/BRIEF.md
# Configurable Macrocell Register

A single-bit storage cell of the kind that sits behind a product-term array in a programmable logic macrocell. A set of configuration inputs picks how the cell behaves. It can act as a D, T, JK or SR flip-flop. It can instead pass its primary term straight through as a combinational output. Its clock can be a global pin of either polarity, that same global clock qualified by an enable, or a clock generated in the logic array. The configuration also sets the value the cell holds after power-up.

Three asynchronous sources can force the cell, and each one overrides the clock. The first is a product-term preset. The second is a product-term clear. The third is a shared active-low global clear, and each cell has its own bit that decides whether it listens to it. A fast-input option takes the D value directly from a pin and skips the logic terms.

An active-low system reset stands in for power-up. While it is low, the cell loads its configured initial value and the configuration inputs are captured. When reset is released, the captured configuration stays frozen until the next reset.

Top module: `pl_macrocell_reg`

## Requirements
- R1: With kind code 0 (D), each active clock edge loads the primary term `a_i` into the register.
- R2: With kind code 1 (T), an active edge inverts the register when `a_i` is 1 and leaves it unchanged when `a_i` is 0.
- R3: With kind code 2 (JK), where J is `a_i` and K is `b_i`, an active edge acts as follows: J=K=0 holds, J=0 K=1 loads 0, J=1 K=0 loads 1, and J=K=1 inverts.
- R4: With kind code 3 (SR), where S is `a_i` and R is `b_i`, an active edge acts as follows: S=R=0 holds, S=1 R=0 loads 1, and any edge with R=1 loads 0, including S=R=1.
- R5: When bypass is configured, `q_o` follows `a_i` combinationally, with no clock edge needed.
- R6: In the global clock modes (mode codes 0 and 1), only the pin selected by `cfg_gsel_i` clocks the register. The active edge is the rising edge of that pin when `cfg_ginv_i` is 0 and the falling edge when it is 1.
- R7: In mode code 1, an active edge with `ce_i` low leaves the register unchanged, and an active edge with `ce_i` high updates it.
- R8: In mode code 2, only a rising edge of `aclk_i` clocks the register, and the global pins have no effect.
- R9: A high `pt_set_i` forces the register to 1 and a high `pt_clr_i` forces it to 0, both without a clock edge. When both are high, the register is 0.
- R10: When `cfg_gclr_en_i` was 1 at reset, a low `gclr_ni` forces the register to 0, and this overrides `pt_set_i`. When `cfg_gclr_en_i` was 0 at reset, `gclr_ni` has no effect.
- R11: While `rst_ni` is low, the register holds `cfg_init_i`.
- R12: With fast input configured, an active edge loads `pin_i` whatever the kind code and the terms are.
- R13: Configuration inputs are captured only while `rst_ni` is low. Changing them after reset is released has no effect on behaviour.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_ni | input | 1 | Active-low system reset, models power-up |
| cfg_kind_i | input | 2 | Storage kind: 0 D, 1 T, 2 JK, 3 SR |
| cfg_bypass_i | input | 1 | 1 selects combinational output |
| cfg_clk_mode_i | input | 2 | 0 global, 1 global with enable, 2 array clock |
| cfg_gsel_i | input | GSEL_W | Global clock pin select |
| cfg_ginv_i | input | 1 | 1 uses inverted global pin |
| cfg_init_i | input | 1 | Power-up value |
| cfg_gclr_en_i | input | 1 | 1 lets the global clear act on this cell |
| cfg_fast_i | input | 1 | 1 loads pin_i as the D value |
| a_i | input | 1 | Primary term (D, T, J or S) |
| b_i | input | 1 | Second term (K or R) |
| pin_i | input | 1 | Direct pin input for the fast path |
| gclk_i | input | NUM_GCLK | Global clock pins |
| aclk_i | input | 1 | Array clock |
| ce_i | input | 1 | Clock enable for mode 1 |
| pt_set_i | input | 1 | Product-term asynchronous preset, active high |
| pt_clr_i | input | 1 | Product-term asynchronous clear, active high |
| gclr_ni | input | 1 | Global clear, active low |
| q_o | output | 1 | Register or bypass output |

## Verification
Two events can land in the same cycle: an asynchronous preset and an asynchronous clear, and, in a second case, the global clear together with the preset. The bench drives both sources at once while no clock edge occurs. It then reads `q_o` after the release of the dominant source, and the level-sensitive preset must take the cell back to 1. A bound checker also judges the same overlap at every active clock edge, which covers an edge that arrives while either force is held.

// File: rtl/pl_macrocell_pkg.sv
package pl_macrocell_pkg;
  typedef enum logic [1:0] {
    FF_D  = 2'd0,
    FF_T  = 2'd1,
    FF_JK = 2'd2,
    FF_SR = 2'd3
  } ff_kind_e;

  typedef enum logic [1:0] {
    CLK_GLOBAL = 2'd0,
    CLK_GATED  = 2'd1,
    CLK_ARRAY  = 2'd2,
    CLK_RSVD   = 2'd3
  } clk_mode_e;
endpackage

// File: rtl/pl_mc_cfg_hold.sv
// Transparent while reset is low, frozen afterwards.
module pl_mc_cfg_hold #(
  parameter int unsigned W = 8
) (
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_latch begin
    if (!rst_ni) q_o <= d_i;
  end
endmodule

// File: rtl/pl_mc_clk_src.sv
module pl_mc_clk_src
  import pl_macrocell_pkg::*;
#(
  parameter int unsigned NUM_GCLK = 2,
  localparam int unsigned GSEL_W = (NUM_GCLK > 1) ? $clog2(NUM_GCLK) : 1
) (
  input  logic [NUM_GCLK-1:0] gclk_i,
  input  logic                aclk_i,
  input  logic [GSEL_W-1:0]   gsel_i,
  input  logic                ginv_i,
  input  clk_mode_e           mode_i,
  output logic                clk_o
);
  logic [NUM_GCLK-1:0] gclk_pol;

  for (genvar i = 0; i < NUM_GCLK; i++) begin : g_pol
    assign gclk_pol[i] = gclk_i[i] ^ ginv_i;
  end

  always_comb begin
    if (mode_i == CLK_ARRAY) clk_o = aclk_i;
    else                     clk_o = gclk_pol[gsel_i];
  end
endmodule

// File: rtl/pl_mc_next.sv
module pl_mc_next
  import pl_macrocell_pkg::*;
(
  input  ff_kind_e kind_i,
  input  logic     fast_i,
  input  logic     a_i,
  input  logic     b_i,
  input  logic     pin_i,
  input  logic     q_i,
  output logic     d_o
);
  always_comb begin
    if (fast_i) begin
      d_o = pin_i;
    end else begin
      unique case (kind_i)
        FF_D:  d_o = a_i;
        FF_T:  d_o = q_i ^ a_i;
        FF_JK: d_o = (a_i & ~q_i) | (~b_i & q_i);
        FF_SR: d_o = ~b_i & (a_i | q_i);  // reset dominates
        default: d_o = q_i;
      endcase
    end
  end
endmodule

// File: rtl/pl_macrocell_reg.sv
module pl_macrocell_reg
  import pl_macrocell_pkg::*;
#(
  parameter int unsigned NUM_GCLK = 2,
  localparam int unsigned GSEL_W = (NUM_GCLK > 1) ? $clog2(NUM_GCLK) : 1
) (
  input  logic                rst_ni,
  input  logic [1:0]          cfg_kind_i,
  input  logic                cfg_bypass_i,
  input  logic [1:0]          cfg_clk_mode_i,
  input  logic [GSEL_W-1:0]   cfg_gsel_i,
  input  logic                cfg_ginv_i,
  input  logic                cfg_init_i,
  input  logic                cfg_gclr_en_i,
  input  logic                cfg_fast_i,
  input  logic                a_i,
  input  logic                b_i,
  input  logic                pin_i,
  input  logic [NUM_GCLK-1:0] gclk_i,
  input  logic                aclk_i,
  input  logic                ce_i,
  input  logic                pt_set_i,
  input  logic                pt_clr_i,
  input  logic                gclr_ni,
  output logic                q_o
);
  localparam int unsigned CFG_W = 2 + 1 + 2 + GSEL_W + 4;

  logic [CFG_W-1:0]  cfg_raw, cfg_q;
  logic [1:0]        kind_q, mode_q;
  logic              bypass_q, ginv_q, init_q, gclr_en_q, fast_q;
  logic [GSEL_W-1:0] gsel_q;

  assign cfg_raw = {cfg_kind_i, cfg_bypass_i, cfg_clk_mode_i, cfg_gsel_i,
                    cfg_ginv_i, cfg_init_i, cfg_gclr_en_i, cfg_fast_i};

  pl_mc_cfg_hold #(.W(CFG_W)) u_cfg (
    .rst_ni (rst_ni),
    .d_i    (cfg_raw),
    .q_o    (cfg_q)
  );

  assign {kind_q, bypass_q, mode_q, gsel_q, ginv_q, init_q, gclr_en_q, fast_q} = cfg_q;

  logic clk_sel;
  pl_mc_clk_src #(.NUM_GCLK(NUM_GCLK)) u_clk (
    .gclk_i (gclk_i),
    .aclk_i (aclk_i),
    .gsel_i (gsel_q),
    .ginv_i (ginv_q),
    .mode_i (clk_mode_e'(mode_q)),
    .clk_o  (clk_sel)
  );

  logic q_r, d_next;
  pl_mc_next u_next (
    .kind_i (ff_kind_e'(kind_q)),
    .fast_i (fast_q),
    .a_i    (a_i),
    .b_i    (b_i),
    .pin_i  (pin_i),
    .q_i    (q_r),
    .d_o    (d_next)
  );

  // Reset loads init; otherwise any clear source beats preset.
  logic gclr_hit, clr_any, async_clr, async_set, upd;
  assign gclr_hit  = gclr_en_q & ~gclr_ni;
  assign clr_any   = pt_clr_i | gclr_hit;
  assign async_clr = ~rst_ni ? ~init_q : clr_any;
  assign async_set = ~rst_ni ?  init_q : (pt_set_i & ~clr_any);
  assign upd       = (clk_mode_e'(mode_q) != CLK_GATED) | ce_i;

  always_ff @(posedge clk_sel or posedge async_clr or posedge async_set) begin
    if (async_clr)      q_r <= 1'b0;
    else if (async_set) q_r <= 1'b1;
    else if (upd)       q_r <= d_next;
  end

  assign q_o = bypass_q ? a_i : q_r;
endmodule

// File: rtl/pl_macrocell_reg_chk.sv
module pl_macrocell_reg_chk (
  input logic clk_sel,
  input logic rst_ni,
  input logic pt_set_i,
  input logic pt_clr_i,
  input logic gclr_ni,
  input logic gclr_en,
  input logic bypass,
  input logic a_i,
  input logic q_r,
  input logic q_o
);
  assert_clr_wins_R9: assert property (@(posedge clk_sel) disable iff (!rst_ni)
    pt_clr_i |-> !q_r);

  assert_preset_R9: assert property (@(posedge clk_sel) disable iff (!rst_ni)
    (pt_set_i && !pt_clr_i && !(gclr_en && !gclr_ni)) |-> q_r);

  assert_gclr_R10: assert property (@(posedge clk_sel) disable iff (!rst_ni)
    (gclr_en && !gclr_ni) |-> !q_r);

  assert_bypass_R5: assert property (@(posedge clk_sel) disable iff (!rst_ni)
    bypass |-> (q_o == a_i));
endmodule

bind pl_macrocell_reg pl_macrocell_reg_chk u_chk (
  .clk_sel  (clk_sel),
  .rst_ni   (rst_ni),
  .pt_set_i (pt_set_i),
  .pt_clr_i (pt_clr_i),
  .gclr_ni  (gclr_ni),
  .gclr_en  (gclr_en_q),
  .bypass   (bypass_q),
  .a_i      (a_i),
  .q_r      (q_r),
  .q_o      (q_o)
);

// File: tb/pl_macrocell_reg_test.sv
module pl_macrocell_reg_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = CLK_PERIOD / 2;
  localparam int NUM_GCLK   = 2;
  localparam int WD_LIMIT   = 20000;
  localparam int NVEC       = 16;
  // {kind[1:0], init, a, b, expected}
  localparam logic [5:0] VEC [NVEC] = '{
    6'b00_0_1_0_1, 6'b00_1_0_0_0,
    6'b01_0_1_0_1, 6'b01_1_1_0_0, 6'b01_1_0_0_1,
    6'b10_0_0_0_0, 6'b10_1_0_0_1, 6'b10_1_0_1_0,
    6'b10_0_1_0_1, 6'b10_0_1_1_1, 6'b10_1_1_1_0,
    6'b11_1_0_0_1, 6'b11_0_1_0_1, 6'b11_1_0_1_0,
    6'b11_1_1_1_0, 6'b11_0_0_1_0
  };

  logic clk = 1'b0;
  logic rst_ni;
  logic [1:0] cfg_kind_i, cfg_clk_mode_i;
  logic cfg_bypass_i, cfg_ginv_i, cfg_init_i, cfg_gclr_en_i, cfg_fast_i;
  logic [0:0] cfg_gsel_i;
  logic a_i, b_i, pin_i, aclk_i, ce_i, pt_set_i, pt_clr_i, gclr_ni;
  logic [NUM_GCLK-1:0] gclk_i;
  logic q_o;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  pl_macrocell_reg #(.NUM_GCLK(NUM_GCLK)) uut (
    .rst_ni(rst_ni), .cfg_kind_i(cfg_kind_i), .cfg_bypass_i(cfg_bypass_i),
    .cfg_clk_mode_i(cfg_clk_mode_i), .cfg_gsel_i(cfg_gsel_i), .cfg_ginv_i(cfg_ginv_i),
    .cfg_init_i(cfg_init_i), .cfg_gclr_en_i(cfg_gclr_en_i), .cfg_fast_i(cfg_fast_i),
    .a_i(a_i), .b_i(b_i), .pin_i(pin_i), .gclk_i(gclk_i), .aclk_i(aclk_i),
    .ce_i(ce_i), .pt_set_i(pt_set_i), .pt_clr_i(pt_clr_i), .gclr_ni(gclr_ni),
    .q_o(q_o)
  );

  always #(HALF) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WD_LIMIT) begin
      total = total + 1;
      bad   = bad + 1;
      $display("FAIL watchdog (all reqs) got timeout exp completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s got %0b exp %0b", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] kind, input logic init, input logic byp,
                          input logic [1:0] mode, input logic gsel, input logic inv,
                          input logic gclr_en, input logic fast);
    rst_ni = 1'b0;
    cfg_kind_i = kind; cfg_init_i = init; cfg_bypass_i = byp;
    cfg_clk_mode_i = mode; cfg_gsel_i = gsel; cfg_ginv_i = inv;
    cfg_gclr_en_i = gclr_en; cfg_fast_i = fast;
    gclk_i = {NUM_GCLK{inv}}; aclk_i = 1'b0; ce_i = 1'b0;
    a_i = 1'b0; b_i = 1'b0; pin_i = 1'b0;
    pt_set_i = 1'b0; pt_clr_i = 1'b0; gclr_ni = 1'b1;
    #(CLK_PERIOD);
    rst_ni = 1'b1;
    #(CLK_PERIOD);
  endtask

  task automatic toggle_g(input int idx);
    gclk_i[idx] = ~gclk_i[idx];
    #(HALF);
  endtask

  task automatic pulse_g(input int idx);
    toggle_g(idx);
    toggle_g(idx);
  endtask

  task automatic pulse_a();
    aclk_i = 1'b1; #(HALF);
    aclk_i = 1'b0; #(HALF);
  endtask

  initial begin
    rst_ni = 1'b0;
    do_reset(2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);

    // Storage kinds, one edge each from a known power-up value
    for (int i = 0; i < NVEC; i++) begin
      logic [5:0] v;
      string tag;
      v = VEC[i];
      do_reset(v[5:4], v[3], 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
      check("R11 init", q_o, v[3]);
      a_i = v[2]; b_i = v[1];
      #1;
      pulse_g(0);
      case (v[5:4])
        2'd0: tag = "R1 d";
        2'd1: tag = "R2 t";
        2'd2: tag = "R3 jk";
        default: tag = "R4 sr";
      endcase
      check(tag, q_o, v[0]);
    end

    // R5 bypass: no clock needed
    do_reset(2'd0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    a_i = 1'b1; #1;
    check("R5 bypass high", q_o, 1'b1);
    a_i = 1'b0; #1;
    check("R5 bypass low", q_o, 1'b0);

    // R6 pin 1, inverted polarity
    do_reset(2'd0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0);
    a_i = 1'b1; #1;
    pulse_g(0);
    check("R6 other pin ignored", q_o, 1'b0);
    toggle_g(1);
    check("R6 falling edge loads", q_o, 1'b1);
    a_i = 1'b0; #1;
    toggle_g(1);
    check("R6 rising edge ignored", q_o, 1'b1);
    toggle_g(1);
    check("R6 next falling edge", q_o, 1'b0);

    // R7 gated global clock
    do_reset(2'd0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    a_i = 1'b1; ce_i = 1'b0; #1;
    pulse_g(0);
    check("R7 enable low holds", q_o, 1'b0);
    ce_i = 1'b1; #1;
    pulse_g(0);
    check("R7 enable high loads", q_o, 1'b1);

    // R8 array clock
    do_reset(2'd0, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0);
    a_i = 1'b1; #1;
    pulse_g(0);
    pulse_g(1);
    check("R8 global pins ignored", q_o, 1'b0);
    pulse_a();
    check("R8 array edge loads", q_o, 1'b1);

    // R9 product-term preset / clear
    do_reset(2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    pt_set_i = 1'b1; #1;
    check("R9 preset", q_o, 1'b1);
    pt_clr_i = 1'b1; #1;
    check("R9 clear beats preset", q_o, 1'b0);
    a_i = 1'b1; #1;
    pulse_g(0);
    check("R9 clear beats edge", q_o, 1'b0);
    pt_clr_i = 1'b0; #1;
    check("R9 preset resumes", q_o, 1'b1);
    pt_set_i = 1'b0; #1;

    // R10 global clear enabled
    do_reset(2'd0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0);
    pt_set_i = 1'b1; gclr_ni = 1'b0; #1;
    check("R10 gclr beats preset", q_o, 1'b0);
    gclr_ni = 1'b1; #1;
    check("R10 gclr release", q_o, 1'b1);
    pt_set_i = 1'b0; #1;
    // R10 global clear disabled
    do_reset(2'd0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    gclr_ni = 1'b0; #1;
    check("R10 gclr disabled", q_o, 1'b1);
    gclr_ni = 1'b1; #1;

    // R12 fast input overrides T behaviour
    do_reset(2'd1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    pin_i = 1'b1; a_i = 1'b0; #1;
    pulse_g(0);
    check("R12 fast load 1", q_o, 1'b1);
    pin_i = 1'b0; a_i = 1'b1; #1;
    pulse_g(0);
    check("R12 fast load 0", q_o, 1'b0);

    // R13 config frozen after reset
    do_reset(2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    cfg_kind_i = 2'd1; cfg_bypass_i = 1'b1; cfg_init_i = 1'b1; cfg_gsel_i = 1'b1;
    a_i = 1'b1; #1;
    check("R13 init unchanged", q_o, 1'b0);
    pulse_g(0);
    check("R13 pin select kept", q_o, 1'b1);
    pulse_g(0);
    check("R13 kind kept", q_o, 1'b1);
    a_i = 1'b0; #1;
    check("R13 bypass not taken", q_o, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule